// File: doc/BRIEF.md
# Cascaded Two-Group DMA Request Arbiter

This block picks which of eight DMA channels is served next. The channels form two groups of four. The upper group holds channels 4 to 7. The lower group holds channels 0 to 3. The lower group never competes directly. Whenever any of its enabled channels is requesting, it raises a request on upper slot 4, the cascade slot. When the cascade slot wins, the grant passes down to the winner inside the lower group. Physical channel 4 therefore cannot be granted, and its own request line has no effect.

Each group has a write-only 8-bit command register. Bit 4 of that register selects the arbitration mode, and bit 2 switches the group off. A write takes effect at the clock edge that captures it. The arbitration in that same cycle still uses the old settings.

A grant is registered and held until the transfer-done pulse. No new arbitration happens while a grant is out. The grant output is a status level, not a stream, so there is no back-pressure. The done pulse alone releases the grant. After a release, the arbiter is idle for one cycle before it grants again.

Top module: `dma_cascade_arbiter`

## Requirements
- R1: After reset, no grant is out (`grant_vld`=0, `grant`=0, `grant_ch`=0). Both groups are enabled and both use fixed order.
- R2: A write with `cmd_wr`=1 is decoded as follows:
  - At `cmd_addr`=08h it updates the lower group, and at D0h it updates the upper group.
  - Data bit 4 selects the mode (1 = rotating, 0 = fixed), and data bit 2 switches the group off (1 = off).
  - All other data bits are ignored.
  - A write to any other address changes nothing.
- R3: In fixed order, the lowest slot of a group wins. In the upper group, the cascade slot 4 ranks above channels 5, 6 and 7.
- R4: In rotating order, when a served grant ends, that channel becomes the lowest priority in its group. A grant that passes through the cascade also moves the cascade slot to lowest priority in the upper group, if the upper group is rotating.
- R5: Channels 0 to 3 win only through the cascade slot. `req[4]` is ignored, and `grant[4]` is never set.
- R6: If the lower group is off, channels 0 to 3 are never granted. If the upper group is off, no channel is granted.
- R7: Grant timing works as follows:
  - When the arbiter is idle and a request is seen at a clock edge, the grant appears after that edge.
  - The grant then stays unchanged until an edge where `xfer_done`=1.
  - At that edge the grant is dropped, and the next grant can come one edge later.
- R8: `grant` is one-hot or zero. `grant_ch` holds the granted channel number while `grant_vld`=1, and is 0 otherwise.
- R9: `xfer_done` while no grant is out has no effect on outputs or on rotation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_addr | input | 8 | Command register address (08h lower group, D0h upper group) |
| cmd_data | input | 8 | Command data: bit 4 selects rotating mode, bit 2 switches the group off |
| req | input | 8 | Per-channel request lines |
| xfer_done | input | 1 | Transfer-done pulse that releases the current grant |
| grant | output | 8 | One-hot grant |
| grant_vld | output | 1 | A grant is active |
| grant_ch | output | 3 | Number of the granted channel |

## Verification
The bench builds the block with its default parameters: four channels per group, with the command registers at 08h and D0h. With four slots per group, a rotating group wraps back to its first channel after four services. The bench walks through that wrap in both groups, including the case where the cascade slot rotates in the upper group while the lower group rotates beneath it. These defaults also bring within reach:
- disabling each group in turn;
- the ignored request line of channel 4;
- writes that set reserved bits or target an unused address.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // decoded command register state of one channel group
  typedef struct packed {
    logic rotate;  // 1: rotating order, 0: fixed order
    logic off;     // 1: group switched off
  } grp_mode_t;

  localparam int          MODE_BIT  = 4;
  localparam int          OFF_BIT   = 2;
  localparam logic [7:0]  RSVD_MASK = 8'hEB;
endpackage

// File: rtl/dma_grp_cmd.sv
module dma_grp_cmd
  import dma_arb_pkg::*;
#(
  parameter logic [7:0] ADDR = 8'h08
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [7:0] addr,
  input  logic [7:0] data,
  output grp_mode_t mode
);
  logic hit;
  logic rsvd_set;

  assign hit      = wr && (addr == ADDR);
  assign rsvd_set = |(data & RSVD_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '{rotate: 1'b0, off: 1'b0};
    end else if (hit) begin
      mode.rotate <= data[MODE_BIT];
      mode.off    <= data[OFF_BIT];
    end
  end

  // R2: reserved bits do not keep the defined fields from taking effect
  a_r2_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    hit && rsvd_set |=> mode.off == $past(data[OFF_BIT]));

  // R2: without a matching write the register keeps its value
  a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(mode));
endmodule

// File: rtl/dma_grp_arb.sv
module dma_grp_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          rotate,
  input  logic          upd,
  input  logic [IW-1:0] served,
  output logic          any,
  output logic [IW-1:0] win
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] slot;

  // walk the slots from highest to lowest priority
  always_comb begin
    any  = 1'b0;
    win  = '0;
    slot = '0;
    for (int k = 0; k < N; k++) begin
      slot = rotate ? IW'(ptr + IW'(k)) : IW'(k);
      if (!any && req[slot]) begin
        any = 1'b1;
        win = slot;
      end
    end
  end

  // rotating order: the slot after the served one becomes the top
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (upd && rotate) begin
      ptr <= served + 1'b1;
    end
  end

  // R3: the winner is always a requesting slot
  a_r3_win_requests: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[win]);

  // R3: no request means no winner
  a_r3_idle_no_win: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !any);

  // R9: rotation state only moves on a served completion
  a_r9_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(ptr));
endmodule

// File: rtl/dma_cascade_arbiter.sv
module dma_cascade_arbiter
  import dma_arb_pkg::*;
#(
  parameter int         GRP_CH  = 4,
  parameter logic [7:0] LO_ADDR = 8'h08,
  parameter logic [7:0] HI_ADDR = 8'hD0,
  localparam int        NCH     = 2 * GRP_CH,
  localparam int        IW      = $clog2(GRP_CH),
  localparam int        CW      = IW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [7:0]     cmd_addr,
  input  logic [7:0]     cmd_data,
  input  logic [NCH-1:0] req,
  input  logic           xfer_done,
  output logic [NCH-1:0] grant,
  output logic           grant_vld,
  output logic [CW-1:0]  grant_ch
);
  grp_mode_t modes [2];

  for (genvar g = 0; g < 2; g++) begin : g_cmd
    localparam logic [7:0] A = (g == 0) ? LO_ADDR : HI_ADDR;
    dma_grp_cmd #(.ADDR(A)) u_cmd (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (cmd_wr),
      .addr (cmd_addr),
      .data (cmd_data),
      .mode (modes[g])
    );
  end

  logic              busy;
  logic [CW-1:0]     gch;
  logic [GRP_CH-1:0] lo_req, hi_req;
  logic              lo_any, hi_any;
  logic [IW-1:0]     lo_win, hi_win;
  logic              lo_upd, hi_upd;
  logic [IW-1:0]     hi_served;
  logic [CW-1:0]     next_ch;

  // lower group requests, then the upper group with slot 0 as the cascade
  assign lo_req = modes[0].off ? '0 : req[GRP_CH-1:0];
  assign hi_req = modes[1].off ? '0 : {req[NCH-1:GRP_CH+1], lo_any};

  assign hi_upd    = busy && xfer_done;
  assign lo_upd    = busy && xfer_done && !gch[CW-1];
  assign hi_served = gch[CW-1] ? gch[IW-1:0] : '0;

  dma_grp_arb #(.N(GRP_CH)) u_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (lo_req),
    .rotate(modes[0].rotate),
    .upd   (lo_upd),
    .served(gch[IW-1:0]),
    .any   (lo_any),
    .win   (lo_win)
  );

  dma_grp_arb #(.N(GRP_CH)) u_hi (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (hi_req),
    .rotate(modes[1].rotate),
    .upd   (hi_upd),
    .served(hi_served),
    .any   (hi_any),
    .win   (hi_win)
  );

  // a cascade win resolves to the lower group's winner
  assign next_ch = (hi_win == '0) ? {1'b0, lo_win} : {1'b1, hi_win};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      gch  <= '0;
    end else if (!busy) begin
      if (hi_any) begin
        busy <= 1'b1;
        gch  <= next_ch;
      end
    end else if (xfer_done) begin
      busy <= 1'b0;
    end
  end

  assign grant_vld = busy;
  assign grant_ch  = busy ? gch : '0;
  assign grant     = busy ? (NCH'(1) << gch) : '0;

  // R8: at most one grant line
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8: the channel number matches the grant line
  a_r8_code_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> grant[grant_ch]);

  // R5: the cascade channel itself is never granted
  a_r5_no_cascade_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !grant[GRP_CH]);

  // R7: a grant holds until done
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && !xfer_done |=> grant_vld && $stable(grant));

  // R7: done drops the grant
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && xfer_done |=> !grant_vld);

  // R6: upper group off keeps everything idle
  a_r6_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
    modes[1].off && !grant_vld |=> !grant_vld);

  // R6: lower group off keeps channels 0..3 out
  a_r6_lower_off: assert property (@(posedge clk) disable iff (!rst_n)
    modes[0].off && !grant_vld |=> !(grant_vld && !grant_ch[CW-1]));

  // R3: a new grant goes to a channel that was requesting
  a_r3_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) && grant_ch[CW-1] |-> |(grant & $past(req)));
endmodule

// File: tb/test_dma_cascade_arbiter.sv
module test_dma_cascade_arbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [7:0] req = '0;
  logic       xfer_done = 1'b0;
  logic [7:0] grant;
  logic       grant_vld;
  logic [2:0] grant_ch;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_cascade_arbiter i_dma_cascade_arbiter (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .req      (req),
    .xfer_done(xfer_done),
    .grant    (grant),
    .grant_vld(grant_vld),
    .grant_ch (grant_ch)
  );

  int    vectors = 0;
  int    miscmp  = 0;
  string tag     = "R1";

  // behavioural reference state
  int m_lo_rot, m_lo_off, m_hi_rot, m_hi_off, m_lo_ptr, m_hi_ptr, m_busy, m_ch;

  function automatic int pick(logic [3:0] r, int rot, int ptr);
    for (int k = 0; k < 4; k++) begin
      int c;
      c = rot ? (ptr + k) % 4 : k;
      if (r[c]) return c;
    end
    return -1;
  endfunction

  task automatic model_reset();
    m_lo_rot = 0; m_lo_off = 0; m_hi_rot = 0; m_hi_off = 0;
    m_lo_ptr = 0; m_hi_ptr = 0; m_busy = 0; m_ch = 0;
  endtask

  task automatic model_step();
    logic [3:0] lr, ur;
    int w;
    if (m_busy == 0) begin
      lr = m_lo_off ? 4'b0 : req[3:0];
      ur = {req[7:5], |lr};
      if (m_hi_off) ur = 4'b0;
      w = pick(ur, m_hi_rot, m_hi_ptr);
      if (w >= 0) begin
        m_busy = 1;
        m_ch = (w == 0) ? pick(lr, m_lo_rot, m_lo_ptr) : 4 + w;
      end
    end else if (xfer_done) begin
      if (m_hi_rot) m_hi_ptr = ((m_ch < 4) ? 0 : m_ch - 4) + 1;
      m_hi_ptr = m_hi_ptr % 4;
      if (m_ch < 4 && m_lo_rot) m_lo_ptr = (m_ch + 1) % 4;
      m_busy = 0;
    end
    if (cmd_wr && cmd_addr == 8'h08) begin
      m_lo_rot = cmd_data[4]; m_lo_off = cmd_data[2];
    end
    if (cmd_wr && cmd_addr == 8'hD0) begin
      m_hi_rot = cmd_data[4]; m_hi_off = cmd_data[2];
    end
  endtask

  task automatic compare();
    logic [7:0] eg;
    logic [2:0] ec;
    eg = m_busy ? (8'd1 << m_ch) : 8'd0;
    ec = m_busy ? 3'(m_ch) : 3'd0;
    vectors++;
    if (grant !== eg || grant_ch !== ec || grant_vld !== 1'(m_busy)) begin
      miscmp++;
      $display("FAIL %s model: grant=%h ch=%0d vld=%b expected grant=%h ch=%0d vld=%0d",
               tag, grant, grant_ch, grant_vld, eg, ec, m_busy);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    compare();
  endtask

  task automatic expect_ch(int ch, string t);
    vectors++;
    if (grant_vld !== 1'b1 || grant_ch !== 3'(ch)) begin
      miscmp++;
      $display("FAIL %s: grant_vld=%b grant_ch=%0d expected vld=1 ch=%0d",
               t, grant_vld, grant_ch, ch);
    end
  endtask

  task automatic expect_idle(string t);
    vectors++;
    if (grant_vld !== 1'b0 || grant !== 8'd0) begin
      miscmp++;
      $display("FAIL %s: grant_vld=%b grant=%h expected vld=0 grant=00",
               t, grant_vld, grant);
    end
  endtask

  task automatic wr_cmd(logic [7:0] a, logic [7:0] d);
    if ((d & 8'hEB) != 0) $display("WARN reserved command bits set: addr=%h data=%h", a, d);
    cmd_wr = 1'b1; cmd_addr = a; cmd_data = d;
    cyc();
    cmd_wr = 1'b0;
  endtask

  task automatic serve(int ch, string t);
    for (int i = 0; i < 4; i++) if (!grant_vld) cyc();
    expect_ch(ch, t);
    xfer_done = 1'b1;
    cyc();
    xfer_done = 1'b0;
    expect_idle("R7");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) cyc();
    rst_n = 1'b1;
    tag = "R1";
    expect_idle("R1");
    cyc();
    expect_idle("R1");

    // R3: fixed order in each group, cascade slot ranks highest upstairs
    tag = "R3";
    req = 8'hE0; serve(5, "R3");
    req = 8'hC0; serve(6, "R3");
    req = 8'h2A; serve(1, "R3");
    req = 8'h28; serve(3, "R3");
    req = 8'h00; cyc();

    // R5: channel 4 request alone is ignored
    tag = "R5";
    req = 8'h10; repeat (4) cyc();
    expect_idle("R5");
    req = 8'h00;

    // R9: done while idle changes nothing
    tag = "R9";
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
    expect_idle("R9");
    req = 8'h80; serve(7, "R9");

    // R7: grant held while other requests arrive
    tag = "R7";
    req = 8'h80; cyc();
    expect_ch(7, "R7");
    req = 8'h01; repeat (3) cyc();
    expect_ch(7, "R7");
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
    expect_idle("R7");
    cyc();
    expect_ch(0, "R7");
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
    req = 8'h00; cyc();

    // R4: lower group rotating
    tag = "R4";
    wr_cmd(8'h08, 8'h10);
    req = 8'h0F;
    serve(0, "R4"); serve(1, "R4"); serve(2, "R4"); serve(3, "R4"); serve(0, "R4");
    req = 8'h00; cyc();

    // R4: upper group rotating with the cascade slot in the ring
    wr_cmd(8'hD0, 8'h10);
    req = 8'hE1;
    serve(0, "R4"); serve(5, "R4"); serve(6, "R4"); serve(7, "R4"); serve(0, "R4");
    req = 8'h00; cyc();

    // R6: lower group off
    tag = "R6";
    wr_cmd(8'h08, 8'h04);
    req = 8'h0F; repeat (3) cyc();
    expect_idle("R6");
    req = 8'h4F; serve(6, "R6");
    req = 8'h00; cyc();

    // R6: upper group off shuts out everything
    wr_cmd(8'h08, 8'h00);
    wr_cmd(8'hD0, 8'h04);
    req = 8'hFF; repeat (3) cyc();
    expect_idle("R6");
    req = 8'h00;
    wr_cmd(8'hD0, 8'h00);

    // R2: stray address ignored, reserved bits ignored
    tag = "R2";
    wr_cmd(8'h09, 8'h04);
    req = 8'h02; serve(1, "R2");
    req = 8'h00;
    wr_cmd(8'h08, 8'hEF);
    req = 8'h02; repeat (3) cyc();
    expect_idle("R2");
    req = 8'h00;
    wr_cmd(8'h08, 8'hEB);
    req = 8'h02; serve(1, "R2");
    req = 8'h00; cyc();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule